// File: doc/BRIEF.md
# Sub-word IO access merger

This block sits between a host that issues byte-addressed accesses of one to four bytes and a set of back-end registers that only accept whole, aligned 32-bit words. It decodes a 128-byte window into three targets: a bank of sixteen core registers, a bank of eight DMA registers, and a single bus-control register. The back-end registers are outside the block and appear only as strobes, an index, a write word and read-data inputs.

A write that is narrower than a word, or that does not start on a word boundary, is widened into a full aligned word. The block keeps a shadow copy of the last word written to each target register. The bytes the host supplies go into their byte lanes, and the shadow fills the other lanes. The merged word goes to the back end and into the shadow in the same cycle, so a run of byte writes to one word builds up its value. A read fetches the whole word from the back end. It returns only the requested bytes, shifted down to bit 0, one cycle after the request.

Top module: `subword_io_merger`

## Requirements
- R1: An access whose aligned word address is below 0x40 targets core register `addr[5:2]`. It asserts `core_wr` for a write or `core_rd` for a read, with `core_idx` set to that index.
- R2: An access whose aligned word address is from 0x40 to 0x5F targets DMA register `(addr-0x40)>>2`. It asserts `dma_wr` or `dma_rd`, with `dma_idx` set to that index.
- R3: A write to any offset from 0x70 to 0x73 is aligned to 0x70 and asserts `bus_wr`. A read asserts `bus_rd` only at exactly offset 0x70; a read at 0x71 to 0x73 returns zero.
- R4: A write to offsets 0x60 to 0x6F or 0x74 to 0x7F asserts no write strobe. A read from those offsets asserts no read strobe and returns zero. At most one of the six strobes is high in any cycle.
- R5: An aligned 4-byte write passes `host_wdata` unchanged to `tgt_wdata`.
- R6: A write of size S at byte offset O (O = `addr[1:0]`) places host data byte k in word lane O+k for k < S. Lanes 4 and above are dropped. Every other lane of `tgt_wdata` holds the last word written to that register, or zero if the register has not been written since reset.
- R7: Byte writes to one register in consecutive cycles accumulate, so each write sees the lanes merged by the one before it.
- R8: A read of size S at offset O sets `host_rvalid` in the next cycle. `host_rdata` in that cycle equals the back-end word shifted right by 8*O bits and masked to its low 8*S bits.
- R9: Only sizes 1 to 4 are accepted. An access with `host_size` of 0 or 5 to 7 asserts no strobe, leaves every shadow unchanged and produces no `host_rvalid`.
- R10: After reset `host_rvalid` and `host_rdata` are zero and every shadow word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 3 | Access size in bytes (1 to 4) |
| host_wdata | input | 32 | Write data, low bytes first |
| host_rdata | output | 32 | Read data, aligned down and masked |
| host_rvalid | output | 1 | Read data valid, one cycle after the request |
| core_wr | output | 1 | Write strobe, core bank |
| core_rd | output | 1 | Read strobe, core bank |
| core_idx | output | 4 | Core register index |
| dma_wr | output | 1 | Write strobe, DMA bank |
| dma_rd | output | 1 | Read strobe, DMA bank |
| dma_idx | output | 3 | DMA register index |
| bus_wr | output | 1 | Write strobe, bus-control register |
| bus_rd | output | 1 | Read strobe, bus-control register |
| tgt_wdata | output | 32 | Merged full-word write data |
| core_rdata | input | 32 | Word from the addressed core register |
| dma_rdata | input | 32 | Word from the addressed DMA register |
| bus_rdata | input | 32 | Word from the bus-control register |

## Verification
The block has no parameters, so the bench builds it as it stands. The fixed 128-byte map is small enough for random accesses to reach every offset, every byte position and every size many times. These include unaligned words that run past lane 3 and the hole between the DMA bank and the bus-control register. Directed runs cover the byte-by-byte build-up of one word, the bus-control reads at 0x71 to 0x73, and the illegal sizes.

// File: rtl/subword_io_merger.sv
module subword_io_merger (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic [6:0]  host_addr,
  input  logic [2:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_rvalid,
  output logic        core_wr,
  output logic        core_rd,
  output logic [3:0]  core_idx,
  output logic        dma_wr,
  output logic        dma_rd,
  output logic [2:0]  dma_idx,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [31:0] tgt_wdata,
  input  logic [31:0] core_rdata,
  input  logic [31:0] dma_rdata,
  input  logic [31:0] bus_rdata
);

  localparam int LANES = 4;
  localparam int CORE_N = 16;
  localparam int DMA_N = 8;
  localparam logic [6:0] CORE_END = 7'h40;
  localparam logic [6:0] DMA_END  = 7'h60;
  localparam logic [6:0] BUS_ADDR = 7'h70;
  localparam logic [6:0] BUS_END  = 7'h74;

  logic [31:0] core_sh [CORE_N];
  logic [31:0] dma_sh [DMA_N];
  logic [31:0] bus_sh;

  logic              size_ok, wr_go, rd_go;
  logic [1:0]        off;
  logic [6:0]        word_addr;
  logic              in_core, in_dma, in_bus_w, in_bus_r;
  logic [LANES-1:0]  size_lanes, wr_lanes;
  logic [31:0]       wr_bits, rd_bits, wdata_sh, cur, rd_src;

  assign size_ok   = (host_size >= 3'd1) && (host_size <= 3'd4);
  assign wr_go     = host_valid & host_write & size_ok;
  assign rd_go     = host_valid & ~host_write & size_ok;
  assign off       = host_addr[1:0];
  assign word_addr = {host_addr[6:2], 2'b00};
  assign in_core   = word_addr < CORE_END;
  assign in_dma    = !in_core && (word_addr < DMA_END);
  assign in_bus_w  = word_addr == BUS_ADDR;
  assign in_bus_r  = host_addr == BUS_ADDR;

  assign core_idx = host_addr[5:2];
  assign dma_idx  = host_addr[4:2];
  assign core_wr  = wr_go & in_core;
  assign dma_wr   = wr_go & in_dma;
  assign bus_wr   = wr_go & in_bus_w;
  assign core_rd  = rd_go & in_core;
  assign dma_rd   = rd_go & in_dma;
  assign bus_rd   = rd_go & in_bus_r;

  assign size_lanes = 4'b1111 >> (3'd4 - host_size);
  assign wr_lanes   = size_lanes << off;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_bits[8*g +: 8] = {8{wr_lanes[g]}};
    assign rd_bits[8*g +: 8] = {8{size_lanes[g]}};
  end

  assign wdata_sh = host_wdata << {off, 3'b000};

  always_comb begin
    if (in_core)                  cur = core_sh[core_idx];
    else if (in_dma)              cur = dma_sh[dma_idx];
    else if (word_addr < BUS_END) cur = bus_sh;
    else                          cur = '0;
  end

  assign tgt_wdata = (wdata_sh & wr_bits) | (cur & ~wr_bits);

  always_comb begin
    if (in_core)       rd_src = core_rdata;
    else if (in_dma)   rd_src = dma_rdata;
    else if (in_bus_r) rd_src = bus_rdata;
    else               rd_src = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CORE_N; i++) core_sh[i] <= '0;
      for (int i = 0; i < DMA_N; i++) dma_sh[i] <= '0;
      bus_sh <= '0;
    end else begin
      if (core_wr) core_sh[core_idx] <= tgt_wdata;
      if (dma_wr)  dma_sh[dma_idx]   <= tgt_wdata;
      if (bus_wr)  bus_sh            <= tgt_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_go;
      if (rd_go) host_rdata <= (rd_src >> {off, 3'b000}) & rd_bits;
    end
  end

  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_wr, dma_wr, bus_wr, core_rd, dma_rd, bus_rd}));

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && !(core_rd || dma_rd || bus_rd) |=> host_rdata == 32'h0);

  p_full_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr || dma_wr || bus_wr) && host_size == 3'd4 && off == 2'd0 |-> tgt_wdata == host_wdata);

  p_accumulate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr && $past(core_wr) && core_idx == $past(core_idx) && host_size == 3'd1 && off == 2'd0
    |-> tgt_wdata[31:8] == $past(tgt_wdata[31:8]));

  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> host_rvalid);

  p_bad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !size_ok |-> !(core_wr || dma_wr || bus_wr || core_rd || dma_rd || bus_rd));

  p_bad_size_norv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !host_rvalid);

endmodule

// File: tb/sim_subword_io_merger.sv
module sim_subword_io_merger;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [6:0] host_addr = '0;
  logic [2:0] host_size = 3'd4;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, tgt_wdata, core_rdata, dma_rdata, bus_rdata;
  logic host_rvalid, core_wr, core_rd, dma_wr, dma_rd, bus_wr, bus_rd;
  logic [3:0] core_idx;
  logic [2:0] dma_idx;

  always #10 clk = ~clk;

  subword_io_merger u0 (.*);

  logic [31:0] be_core [16];
  logic [31:0] be_dma [8];
  logic [31:0] be_bus;
  initial begin
    for (int i = 0; i < 16; i++) be_core[i] = '0;
    for (int i = 0; i < 8; i++) be_dma[i] = '0;
    be_bus = '0;
  end
  always @(posedge clk) begin
    if (core_wr) be_core[core_idx] <= tgt_wdata;
    if (dma_wr)  be_dma[dma_idx]   <= tgt_wdata;
    if (bus_wr)  be_bus            <= tgt_wdata;
  end
  assign core_rdata = be_core[core_idx];
  assign dma_rdata  = be_dma[dma_idx];
  assign bus_rdata  = be_bus;

  logic [31:0] m_core [16];
  logic [31:0] m_dma [8];
  logic [31:0] m_bus;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] d,
                                        input int o, input int s);
    logic [31:0] r = cur;
    for (int b = 0; b < 4; b++)
      if (b >= o && b < o + s) r[8*b +: 8] = d[8*(b-o) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input int o, input int s);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (b < s && o + b < 4) r[8*b +: 8] = w[8*(o+b) +: 8];
    return r;
  endfunction

  task automatic access(input bit we, input int a, input int s, input logic [31:0] d);
    int o = a % 4;
    int wa = a - o;
    bit ok = (s >= 1 && s <= 4);
    logic [5:0] exp_st;
    logic [31:0] cur, expw, word;
    string tg;
    host_valid = 1'b1; host_write = we; host_addr = 7'(a);
    host_size = 3'(s); host_wdata = d;
    #5;
    exp_st = '0;
    if (ok && we) begin
      if (wa < 'h40) exp_st[5] = 1; else if (wa < 'h60) exp_st[4] = 1; else if (wa == 'h70) exp_st[3] = 1;
    end
    if (ok && !we) begin
      if (wa < 'h40) exp_st[2] = 1; else if (wa < 'h60) exp_st[1] = 1; else if (a == 'h70) exp_st[0] = 1;
    end
    tg = !ok ? "R9 bad size" : (wa < 'h40) ? "R1 core map" : (wa < 'h60) ? "R2 dma map" :
         (wa >= 'h70 && wa < 'h74) ? "R3 busctl map" : "R4 unmapped";
    chk({core_wr, dma_wr, bus_wr, core_rd, dma_rd, bus_rd} == exp_st, tg,
        32'({core_wr, dma_wr, bus_wr, core_rd, dma_rd, bus_rd}), 32'(exp_st));
    if (exp_st[5] || exp_st[2]) chk(core_idx == 4'(wa / 4), "R1 core index", 32'(core_idx), 32'(wa / 4));
    if (exp_st[4] || exp_st[1]) chk(dma_idx == 3'((wa - 'h40) / 4), "R2 dma index", 32'(dma_idx), 32'((wa - 'h40) / 4));
    cur = (wa < 'h40) ? m_core[wa/4] : (wa < 'h60) ? m_dma[(wa-'h40)/4] : (wa < 'h74) ? m_bus : 32'h0;
    expw = merge(cur, d, o, s);
    if (exp_st[5:3] != 0)
      chk(tgt_wdata == expw, (s == 4 && o == 0) ? "R5 full write" : "R6 merged write", tgt_wdata, expw);
    @(negedge clk);
    chk(host_rvalid == (ok && !we), ok ? "R8 rvalid" : "R9 no rvalid", 32'(host_rvalid), 32'(ok && !we));
    if (ok && !we) begin
      word = exp_st[2] ? m_core[wa/4] : exp_st[1] ? m_dma[(wa-'h40)/4] : exp_st[0] ? m_bus : 32'h0;
      chk(host_rdata == extract(word, o, s), exp_st == 0 ? "R4 unmapped read zero" : "R8 read shift/mask",
          host_rdata, extract(word, o, s));
    end
    if (exp_st[5]) m_core[wa/4] = expw;
    if (exp_st[4]) m_dma[(wa-'h40)/4] = expw;
    if (exp_st[3]) m_bus = expw;
  endtask

  task automatic idle();
    host_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a, s, r;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) m_core[i] = '0;
    for (int i = 0; i < 8; i++) m_dma[i] = '0;
    m_bus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rvalid == 0, "R10 reset rvalid", 32'(host_rvalid), 0);
    chk(host_rdata == 0, "R10 reset rdata", host_rdata, 0);
    access(1, 'h05, 1, 32'h0000_00AB);
    access(1, 'h44, 2, 32'h0000_1234);
    idle();
    access(1, 'h10, 1, 32'h11); access(1, 'h11, 1, 32'h22);
    access(1, 'h12, 1, 32'h33); access(1, 'h13, 1, 32'h44);
    access(0, 'h10, 4, 0);
    chk(host_rdata == 32'h4433_2211, "R7 accumulated word", host_rdata, 32'h4433_2211);
    access(1, 'h20, 4, 32'hDEAD_BEEF);
    access(1, 'h20, 1, 32'h0000_0055);
    access(1, 'h23, 4, 32'hCAFE_F00D);
    access(0, 'h22, 4, 0);
    access(1, 'h70, 4, 32'h8765_4321);
    access(1, 'h71, 1, 32'h99);
    access(0, 'h70, 4, 0);
    access(0, 'h71, 1, 0); access(0, 'h73, 1, 0);
    access(1, 'h64, 4, 32'hFFFF_FFFF); access(1, 'h6E, 2, 32'hAAAA);
    access(1, 'h7C, 4, 32'h1111_1111); access(0, 'h78, 4, 0); access(0, 'h60, 2, 0);
    access(0, 'h70, 4, 0);
    access(1, 'h08, 0, 32'h7777_7777); access(0, 'h08, 5, 0); access(1, 'h08, 7, 32'h1);
    access(0, 'h08, 4, 0);
    for (int i = 0; i < 2000; i++) begin
      a = int'($urandom % 128);
      r = int'($urandom % 20);
      s = (r == 0) ? 0 : (r == 1) ? 5 + int'($urandom % 3) : 1 + (r % 4);
      access($urandom % 2 == 1, a, s, $urandom);
      if ($urandom % 8 == 0) idle();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule